// File: doc/BRIEF.md
# Chroma-Subsampling MCU Formatter

This block sits between a camera pixel stream and a block transform stage. It accepts packed YUV 4:2:2 pixels on a 64-bit bus, gathers them into strips of 16 image lines and holds each strip in one of two line-buffer banks. Once a strip is complete, it is read out as a series of minimum coded units (MCUs), each 16 pixels wide. An MCU is emitted as six 8x8 blocks: four luma blocks, then one U block, then one V block.

The chroma planes arrive with full vertical resolution. The block halves that resolution on the read side: each pair of adjacent chroma lines is averaged, with the result rounded half up. Each luma and chroma sample leaves as a signed two's-complement byte, with 128 already removed. Every output beat carries one sample. The tag fields on each beat give the component, the block index inside the MCU and the raster position inside the block, so a transform stage downstream needs no counters of its own.

Because there are two banks, the next strip can be written while the current one is read. Input is refused only when both banks hold strips that have not been read yet.

Top module: `mcu_formatter`

## Requirements
- R1: An input word is taken on a clock edge where both in_valid and in_ready are high. Each word carries four pixels in the byte order Y0, U0, Y1, V0, Y2, U1, Y3, V1, starting at bits [7:0]. The first pixel in a word is the leftmost. Each U/V pair is shared by two horizontally adjacent pixels.
- R2: out_valid stays low until all 16 lines (IMG_W pixels each) of a strip have been accepted. It rises on the cycle after the last word of the strip is taken.
- R3: Each MCU is sent as six blocks with out_blk running 0 to 5. Blocks 0 to 3 are luma, in the order top-left, top-right, bottom-left, bottom-right. Block 4 is U and block 5 is V. out_comp is 0 for Y, 1 for U and 2 for V.
- R4: Within a block, out_pos runs 0 to 63 in row-major order (row = pos/8, column = pos%8). out_last is high exactly at pos 63.
- R5: A luma sample is the source byte minus 128, as a signed 8-bit value.
- R6: For chroma block row r and column c, the sample is the rounded-half-up mean of source chroma lines 2r and 2r+1 at chroma column mcu*8+c, minus 128.
- R7: The MCUs of a strip come out from left to right, and strips come out in the order they arrived.
- R8: While one strip is being read out, the words of the next strip are accepted without stalls. in_ready goes low only while both banks hold unread strips.
- R9: While out_valid is high and out_ready is low, out_valid and all output fields hold their values.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word can be accepted |
| in_data | input | 64 | Four packed 4:2:2 pixels |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream accepts the sample |
| out_data | output | 8 | Level-shifted signed sample |
| out_comp | output | 2 | Component: 0 Y, 1 U, 2 V |
| out_blk | output | 3 | Block index within the MCU |
| out_pos | output | 6 | Raster position within the block |
| out_last | output | 1 | Last sample of a block |

## Verification
Chroma line pairs are filled with values whose sums are odd, so the half-up rounding is exercised: a design that truncates returns values one lower. Luma extremes of 0 and 255 are used, so a design that gets the sign handling of the level shift wrong shows up as values of +128 or an inverted sign. The bench holds back the last word of a strip, which catches any block that starts output before the strip is complete. It also fills both banks while the output is stalled: a single-banked design would refuse the second strip, and a design that overwrites a bank would corrupt the data later read from it. Random back-pressure on the output catches fields that change while a beat is stalled, and block-order checks catch swapped luma quadrants.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
   typedef enum logic [1:0] {
      COMP_Y = 2'd0,
      COMP_U = 2'd1,
      COMP_V = 2'd2
   } comp_e;
   localparam int STRIP_LINES    = 16;
   localparam int BLK_SIDE       = 8;
   localparam int BLKS_PER_MCU   = 6;
   localparam int MCU_WIDTH      = 16;
   localparam int PIX_PER_WORD   = 4;
endpackage

// File: rtl/fmt_chroma_pair.sv
module fmt_chroma_pair #(
   parameter int ROUND_UP = 1
) (
   input  logic [7:0] upper_s,
   input  logic [7:0] lower_s,
   output logic [7:0] mean_s
);
   logic [8:0] pair_sum;
   assign pair_sum = {1'b0, upper_s} + {1'b0, lower_s};

   generate
      if (ROUND_UP != 0) begin : g_half_up
         assign mean_s = 8'((pair_sum + 9'd1) >> 1);
      end else begin : g_trunc
         assign mean_s = 8'(pair_sum >> 1);
      end
   endgenerate
endmodule

// File: rtl/fmt_strip_writer.sv
module fmt_strip_writer #(
   parameter int WORDS_PER_LINE = 8,
   parameter int LINES          = 16,
   localparam int WW = (WORDS_PER_LINE > 1) ? $clog2(WORDS_PER_LINE) : 1,
   localparam int LW = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [1:0]    bank_full,
   output logic          in_ready,
   output logic          wr_en,
   output logic          wr_bank,
   output logic [LW-1:0] wr_line,
   output logic [WW-1:0] wr_word,
   output logic          strip_done
);
   assign in_ready   = !bank_full[wr_bank];
   assign wr_en      = in_valid && in_ready;
   assign strip_done = wr_en && (wr_word == WW'(WORDS_PER_LINE - 1))
                             && (wr_line == LW'(LINES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_bank <= 1'b0;
         wr_line <= '0;
         wr_word <= '0;
      end else if (wr_en) begin
         if (wr_word == WW'(WORDS_PER_LINE - 1)) begin
            wr_word <= '0;
            if (wr_line == LW'(LINES - 1)) begin
               wr_line <= '0;
               wr_bank <= !wr_bank;
            end else begin
               wr_line <= wr_line + 1'b1;
            end
         end else begin
            wr_word <= wr_word + 1'b1;
         end
      end
   end

   a_r8_no_write_into_full: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !bank_full[wr_bank]);
endmodule

// File: rtl/fmt_mcu_reader.sv
module fmt_mcu_reader #(
   parameter int MCUS = 2,
   localparam int MW = (MCUS > 1) ? $clog2(MCUS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    bank_full,
   input  logic          out_ready,
   output logic          out_valid,
   output logic          rd_bank,
   output logic [MW-1:0] rd_mcu,
   output logic [2:0]    rd_blk,
   output logic [5:0]    rd_pos,
   output logic          rd_last,
   output logic          strip_read
);
   logic fire;
   logic blk_end;

   assign out_valid  = bank_full[rd_bank];
   assign fire       = out_valid && out_ready;
   assign rd_last    = (rd_pos == 6'd63);
   assign blk_end    = (rd_blk == 3'd5);
   assign strip_read = fire && rd_last && blk_end && (rd_mcu == MW'(MCUS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_bank <= 1'b0;
         rd_mcu  <= '0;
         rd_blk  <= '0;
         rd_pos  <= '0;
      end else if (fire) begin
         rd_pos <= rd_pos + 6'd1;
         if (rd_last) begin
            if (blk_end) begin
               rd_blk <= '0;
               if (rd_mcu == MW'(MCUS - 1)) begin
                  rd_mcu  <= '0;
                  rd_bank <= !rd_bank;
               end else begin
                  rd_mcu <= rd_mcu + 1'b1;
               end
            end else begin
               rd_blk <= rd_blk + 3'd1;
            end
         end
      end
   end

   a_r4_pos_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !rd_last) |=> (rd_pos == $past(rd_pos) + 6'd1) && $stable(rd_blk));
   a_r3_block_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && rd_last && !blk_end) |=> (rd_blk == $past(rd_blk) + 3'd1) && (rd_pos == 6'd0));
   a_r3_block_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (rd_blk <= 3'd5));
endmodule

// File: rtl/mcu_formatter.sv
module mcu_formatter
   import fmt_pkg::*;
#(
   parameter int IMG_W       = 32,
   parameter int IN_W        = 64,
   parameter int CHROMA_RND  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [63:0]       in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic signed [7:0] out_data,
   output logic [1:0]        out_comp,
   output logic [2:0]        out_blk,
   output logic [5:0]        out_pos,
   output logic              out_last
);
   localparam int WPL    = IMG_W / PIX_PER_WORD;
   localparam int CW     = IMG_W / 2;
   localparam int MCUS   = IMG_W / MCU_WIDTH;
   localparam int YDEPTH = 2 * STRIP_LINES * IMG_W;
   localparam int CDEPTH = 2 * STRIP_LINES * CW;
   localparam int YA_W   = $clog2(YDEPTH);
   localparam int CA_W   = $clog2(CDEPTH);
   localparam int WW     = (WPL > 1) ? $clog2(WPL) : 1;
   localparam int LW     = $clog2(STRIP_LINES);
   localparam int MW     = (MCUS > 1) ? $clog2(MCUS) : 1;

   generate
      if (IN_W != 64) begin : g_bad_bus
         $error("mcu_formatter: input bus must be 64 bits");
      end
      if ((IMG_W % MCU_WIDTH) != 0 || IMG_W < MCU_WIDTH) begin : g_bad_width
         $error("mcu_formatter: IMG_W must be a nonzero multiple of 16");
      end
   endgenerate

   logic [1:0]    bank_full;
   logic          wr_en, wr_bank, strip_done;
   logic [LW-1:0] wr_line;
   logic [WW-1:0] wr_word;
   logic          rd_bank, strip_read;
   logic [MW-1:0] rd_mcu;
   logic [2:0]    rd_blk;
   logic [5:0]    rd_pos;

   fmt_strip_writer #(.WORDS_PER_LINE(WPL), .LINES(STRIP_LINES)) u_wr (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bank_full(bank_full),
      .in_ready(in_ready), .wr_en(wr_en), .wr_bank(wr_bank), .wr_line(wr_line),
      .wr_word(wr_word), .strip_done(strip_done));

   fmt_mcu_reader #(.MCUS(MCUS)) u_rd (
      .clk(clk), .rst_n(rst_n), .bank_full(bank_full), .out_ready(out_ready),
      .out_valid(out_valid), .rd_bank(rd_bank), .rd_mcu(rd_mcu), .rd_blk(rd_blk),
      .rd_pos(rd_pos), .rd_last(out_last), .strip_read(strip_read));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_full <= 2'b00;
      end else begin
         if (strip_done) bank_full[wr_bank] <= 1'b1;
         if (strip_read) bank_full[rd_bank] <= 1'b0;
      end
   end

   // Line buffer storage: one luma and two chroma planes, two banks each.
   logic [7:0] ymem [YDEPTH];
   logic [7:0] umem [CDEPTH];
   logic [7:0] vmem [CDEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int k = 0; k < PIX_PER_WORD; k++) begin
            ymem[YA_W'((int'(wr_bank) * STRIP_LINES + int'(wr_line)) * IMG_W
                       + int'(wr_word) * PIX_PER_WORD + k)] <= in_data[16*k +: 8];
         end
         for (int j = 0; j < 2; j++) begin
            umem[CA_W'((int'(wr_bank) * STRIP_LINES + int'(wr_line)) * CW
                       + int'(wr_word) * 2 + j)] <= in_data[32*j + 8 +: 8];
            vmem[CA_W'((int'(wr_bank) * STRIP_LINES + int'(wr_line)) * CW
                       + int'(wr_word) * 2 + j)] <= in_data[32*j + 24 +: 8];
         end
      end
   end

   // Read addressing for the current output beat.
   logic [2:0]      pix_row, pix_col;
   logic [YA_W-1:0] y_addr;
   logic [CA_W-1:0] c_addr_hi, c_addr_lo;
   logic [7:0]      u_mean, v_mean, raw_s;

   assign pix_row = rd_pos[5:3];
   assign pix_col = rd_pos[2:0];
   assign y_addr  = YA_W'((int'(rd_bank) * STRIP_LINES + int'({rd_blk[1], pix_row})) * IMG_W
                          + int'(rd_mcu) * MCU_WIDTH + int'(rd_blk[0]) * BLK_SIDE + int'(pix_col));
   assign c_addr_hi = CA_W'((int'(rd_bank) * STRIP_LINES + int'({pix_row, 1'b0})) * CW
                            + int'(rd_mcu) * BLK_SIDE + int'(pix_col));
   assign c_addr_lo = CA_W'((int'(rd_bank) * STRIP_LINES + int'({pix_row, 1'b1})) * CW
                            + int'(rd_mcu) * BLK_SIDE + int'(pix_col));

   fmt_chroma_pair #(.ROUND_UP(CHROMA_RND)) u_uavg (
      .upper_s(umem[c_addr_hi]), .lower_s(umem[c_addr_lo]), .mean_s(u_mean));
   fmt_chroma_pair #(.ROUND_UP(CHROMA_RND)) u_vavg (
      .upper_s(vmem[c_addr_hi]), .lower_s(vmem[c_addr_lo]), .mean_s(v_mean));

   comp_e comp_sel;
   always_comb begin
      if (!rd_blk[2]) begin
         comp_sel = COMP_Y;
         raw_s    = ymem[y_addr];
      end else if (!rd_blk[0]) begin
         comp_sel = COMP_U;
         raw_s    = u_mean;
      end else begin
         comp_sel = COMP_V;
         raw_s    = v_mean;
      end
   end

   // Subtracting 128 from an unsigned byte is an inversion of its top bit.
   assign out_data = signed'({~raw_s[7], raw_s[6:0]});
   assign out_comp = comp_sel;
   assign out_blk  = rd_blk;
   assign out_pos  = rd_pos;

   a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_blk)
                                    && $stable(out_pos) && $stable(out_comp));
   a_r2_valid_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready) && (out_blk == 3'd0) && (out_pos == 6'd0));
   a_r8_refuse_only_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |-> out_valid);
   a_r3_luma_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_blk < 3'd4) |-> (out_comp == 2'd0));
endmodule

// File: tb/tb_mcu_formatter.sv
module tb_mcu_formatter;
   localparam int W      = 32;
   localparam int CWB    = W / 2;
   localparam int WPLB   = W / 4;
   localparam int NSTRIP = 3;
   localparam int BEATS_PER_STRIP = (W / 16) * 6 * 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [63:0] in_data = '0;
   logic out_valid;
   logic out_ready = 1'b0;
   logic signed [7:0] out_data;
   logic [1:0] out_comp;
   logic [2:0] out_blk;
   logic [5:0] out_pos;
   logic out_last;

   always #4 clk = ~clk;

   mcu_formatter #(.IMG_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_comp(out_comp), .out_blk(out_blk),
      .out_pos(out_pos), .out_last(out_last));

   int total = 0;
   int bad = 0;
   int ysrc [NSTRIP][16][W];
   int usrc [NSTRIP][16][CWB];
   int vsrc [NSTRIP][16][CWB];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_word(input int s, input int l, input int w);
      logic [63:0] d;
      for (int k = 0; k < 4; k++) d[16*k +: 8] = 8'(ysrc[s][l][4*w + k]);
      for (int j = 0; j < 2; j++) begin
         d[32*j + 8  +: 8] = 8'(usrc[s][l][2*w + j]);
         d[32*j + 24 +: 8] = 8'(vsrc[s][l][2*w + j]);
      end
      return d;
   endfunction

   task automatic put_word(input logic [63:0] w, input int gap, output int waited);
      waited = 0;
      repeat (gap) begin @(negedge clk); in_valid = 1'b0; end
      @(negedge clk); in_valid = 1'b1; in_data = w;
      while (!in_ready) begin @(negedge clk); waited++; end
   endtask

   task automatic send_strip(input int s, input int words, input bit gaps, output int waits);
      int wt;
      waits = 0;
      for (int n = 0; n < words; n++) begin
         put_word(mk_word(s, n / WPLB, n % WPLB), gaps ? int'($urandom % 3) : 0, wt);
         waits += wt;
      end
   endtask

   task automatic exp_beat(input int k, output int comp, output int blk, output int pos,
                           output int last, output int val);
      int s, r, m, row, col, a, b;
      s   = k / BEATS_PER_STRIP;
      r   = k % BEATS_PER_STRIP;
      m   = r / 384;
      blk = (r % 384) / 64;
      pos = r % 64;
      last = (pos == 63);
      row = pos / 8;
      col = pos % 8;
      if (blk < 4) begin
         comp = 0;
         val = ysrc[s][(blk / 2) * 8 + row][m * 16 + (blk % 2) * 8 + col] - 128;
      end else begin
         comp = (blk == 4) ? 1 : 2;
         a = (blk == 4) ? usrc[s][2*row][m*8 + col] : vsrc[s][2*row][m*8 + col];
         b = (blk == 4) ? usrc[s][2*row+1][m*8 + col] : vsrc[s][2*row+1][m*8 + col];
         val = (a + b + 1) / 2 - 128;
      end
   endtask

   task automatic consume(input int nbeats);
      int ec, eb, ep, el, ev;
      bit stalled;
      logic signed [7:0] held_d;
      logic [5:0] held_p;
      stalled = 1'b0;
      held_d = '0;
      held_p = '0;
      for (int k = 0; k < nbeats; k++) begin
         exp_beat(k, ec, eb, ep, el, ev);
         forever begin
            @(negedge clk);
            if (stalled) begin
               chk(out_valid && out_data == held_d && out_pos == held_p, "R9 hold",
                   int'(out_data), int'(held_d));
            end
            out_ready = ($urandom % 10) < 7;
            stalled = out_valid && !out_ready;
            held_d = out_data;
            held_p = out_pos;
            if (out_valid && out_ready) break;
         end
         chk(int'(out_blk) == eb && int'(out_comp) == ec, "R3 tag",
             int'(out_blk) * 4 + int'(out_comp), eb * 4 + ec);
         chk(int'(out_pos) == ep && int'(out_last) == el, "R4 pos",
             int'(out_pos) * 2 + int'(out_last), ep * 2 + el);
         if (ec == 0) chk(int'(out_data) == ev, "R1 R5 R7 luma", int'(out_data), ev);
         else         chk(int'(out_data) == ev, "R1 R6 R7 chroma", int'(out_data), ev);
      end
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic run_all();
      int waits;
      void'($urandom(32'd20240917));
      for (int s = 0; s < NSTRIP; s++)
         for (int l = 0; l < 16; l++) begin
            for (int x = 0; x < W; x++)
               ysrc[s][l][x] = (s == 2) ? ((x % 2) ? 255 : 0) : int'($urandom % 256);
            for (int x = 0; x < CWB; x++) begin
               usrc[s][l][x] = (s == 2) ? ((l % 2) ? 254 : 255) : int'($urandom % 256);
               vsrc[s][l][x] = (s == 2) ? ((l % 2) ? 1 : 0) : int'($urandom % 256);
            end
         end

      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);
      rst_n = 1'b1;

      // Hold back the final word of the first strip.
      send_strip(0, 16 * WPLB - 1, 1'b0, waits);
      @(negedge clk); in_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk(out_valid == 1'b0, "R2 early", int'(out_valid), 0);
      put_word(mk_word(0, 15, WPLB - 1), 0, waits);
      @(negedge clk); in_valid = 1'b0;
      chk(out_valid == 1'b1, "R2 rise", int'(out_valid), 1);

      // Second strip must enter the other bank while output is stalled.
      send_strip(1, 16 * WPLB, 1'b0, waits);
      @(negedge clk); in_valid = 1'b0;
      chk(waits == 0, "R8 no stall", waits, 0);
      chk(in_ready == 1'b0, "R8 both full", int'(in_ready), 0);
      chk(out_blk == 3'd0 && out_pos == 6'd0, "R7 first strip pending",
          int'(out_blk) * 64 + int'(out_pos), 0);

      fork
         consume(NSTRIP * BEATS_PER_STRIP);
         begin
            send_strip(2, 16 * WPLB, 1'b1, waits);
            @(negedge clk); in_valid = 1'b0;
         end
      join
      repeat (2) @(negedge clk);
      chk(out_valid == 1'b0, "R8 drained", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R8 free", int'(in_ready), 1);
   endtask

   initial begin
      bit wd_hit;
      wd_hit = 1'b0;
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            wd_hit = 1'b1;
         end
      join_any
      disable fork;
      if (wd_hit) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule